// File: doc/BRIEF.md
# Eight-bit accumulator CPU core

A compact multi-cycle processor that runs byte-wide programs out of an external program memory. Every instruction is one byte. Its high nibble selects the operation, and two 2-bit fields name a source register and a destination register. Three instructions take a second byte, which is either an immediate value or a jump address. Data are 8-bit two's-complement values held in three general registers. A single sign flag is written only by the test and compare operations. The only conditional branch is taken when that flag is clear.

The core reads the program through an address output and a data input. It uses a hardwired two-state sequencer: one cycle fetches the opcode byte, and one cycle executes it, which includes consuming the operand byte when there is one. Input bytes arrive from a switch port qualified by a valid line. The core acknowledges each byte it takes. Results leave through a registered output byte with a one-cycle write strobe.

Top module: `cpu8_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `prog_addr` is 0 and both `out_stb` and `sw_take` are low.
- R2: An instruction byte carries the operation in bits 7:4, the source register (Rs) in bits 3:2 and the destination register (Rd) in bits 1:0. The codes 00, 01 and 10 select R0, R1 and R2. Operation 0011 loads the following program byte into Rd. `prog_addr` advances by one for every byte consumed, operand bytes included.
- R3: Operation 0100 sets the sign flag to bit 7 of Rd and writes no register.
- R4: Operation 1001 sets the sign flag to bit 7 of (Rs − Rd) modulo 256 and writes no register.
- R5: Operation 0101 jumps to the address in the following byte when the sign flag is 0. Otherwise execution continues after that address byte.
- R6: Operation 1011 always jumps to the address in the following byte.
- R7: Operation 0110 writes Rd+1 and operation 1100 writes 0−Rd, both modulo 256, into Rd. 0x80 negates to 0x80 and 0xFF increments to 0x00.
- R8: Operation 0111 waits, with `prog_addr` held, while `sw_valid` is low. It writes `sw_data` into Rd on a cycle where `sw_valid` is high, and `sw_take` is then high for exactly the following cycle. Each such instruction consumes one byte.
- R9: Operation 1101 places Rs on `out_data` and raises `out_stb` for exactly one cycle. `out_stb` and `sw_take` are never high together.
- R10: Operation 1010 copies Rs into Rd.
- R11: Increment, negate, copy, input and immediate load leave the sign flag unchanged.
- R12: A write to register code 11 is discarded, and a read of code 11 returns 0. Operations 0000, 0001, 0010, 1000, 1110 and 1111 are one-byte no-ops.
- R13: A loop built from these instructions that reads 0x82, 0x01, 0x02, 0x03 and 0xFE reports 0x02, the magnitude of the largest negative input. With no negative input it reports 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | AW (8) | Program memory address (registered program counter) |
| prog_data | input | DW (8) | Program byte at `prog_addr`, valid in the same cycle |
| sw_data | input | DW (8) | Input switch byte |
| sw_valid | input | 1 | `sw_data` holds a byte to be taken |
| sw_take | output | 1 | One-cycle acknowledge after a byte was captured |
| out_data | output | DW (8) | Last value written by an output instruction |
| out_stb | output | 1 | One-cycle write strobe for `out_data` |

## Verification
The bound checker watches the port-level contract on every cycle. It checks that reset clears the address and strobes, that `prog_addr` only ever steps by one or moves to the byte currently on `prog_data`, that both strobes last a single cycle and never coincide, and that an acknowledge always follows a cycle with `sw_valid` high. Flag semantics, ALU wrap-around, the discarded register code and the silent opcodes cannot be seen from the ports cycle by cycle. Only the bench's small programs show them, by turning the flag and register contents into branch choices and output bytes. The end-to-end search program is likewise shown only by a scenario.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  // Operation codes (bits 7:4 of an instruction byte)
  localparam logic [3:0] OP_LDI = 4'h3;
  localparam logic [3:0] OP_TST = 4'h4;
  localparam logic [3:0] OP_JNN = 4'h5;
  localparam logic [3:0] OP_INC = 4'h6;
  localparam logic [3:0] OP_INP = 4'h7;
  localparam logic [3:0] OP_CMP = 4'h9;
  localparam logic [3:0] OP_MOV = 4'hA;
  localparam logic [3:0] OP_JMP = 4'hB;
  localparam logic [3:0] OP_NEG = 4'hC;
  localparam logic [3:0] OP_OUT = 4'hD;

  typedef enum logic [2:0] {
    ALU_THRU_B,
    ALU_THRU_A,
    ALU_SUB,
    ALU_INC,
    ALU_NEG
  } alu_op_e;

  typedef enum logic {
    ST_FETCH,
    ST_EXEC
  } state_e;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] rs;
    logic [1:0] rd;
  } instr_t;

endpackage

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 3,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] raddr_a,
  input  logic [SW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [NREG-1:0][DW-1:0] regs;

  // Codes at or above NREG decode to nothing: writes drop, reads give 0
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (we) begin
      for (int i = 0; i < NREG; i++) begin
        if (waddr == SW'(i)) regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NREG; i++) begin
      if (raddr_a == SW'(i)) rdata_a = regs[i];
      if (raddr_b == SW'(i)) rdata_b = regs[i];
    end
  end

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_THRU_A: y = a;
      ALU_SUB:    y = a - b;
      ALU_INC:    y = b + DW'(1);
      ALU_NEG:    y = '0 - b;
      default:    y = b;
    endcase
  end

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] sw_data,
  input  logic          sw_valid,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] alu_y,
  output logic [AW-1:0] pc,
  output logic [1:0]    sel_rs,
  output logic [1:0]    sel_rd,
  output alu_op_e       alu_op,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  output logic [DW-1:0] out_data,
  output logic          out_stb,
  output logic          sw_take
);

  state_e        state;
  instr_t        ir;
  logic          sflag;
  logic          in_exec;
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] target;

  assign in_exec = (state == ST_EXEC);
  assign pc_inc  = pc + AW'(1);
  assign target  = AW'(prog_data);
  assign sel_rs  = ir.rs;
  assign sel_rd  = ir.rd;

  // Datapath steering for the execute cycle
  always_comb begin
    alu_op   = ALU_THRU_B;
    rf_we    = 1'b0;
    rf_wdata = alu_y;
    case (ir.op)
      OP_LDI: begin rf_we = in_exec; rf_wdata = prog_data; end
      OP_INP: begin rf_we = in_exec && sw_valid; rf_wdata = sw_data; end
      OP_INC: begin alu_op = ALU_INC;    rf_we = in_exec; end
      OP_NEG: begin alu_op = ALU_NEG;    rf_we = in_exec; end
      OP_MOV: begin alu_op = ALU_THRU_A; rf_we = in_exec; end
      OP_CMP: alu_op = ALU_SUB;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      ir       <= '0;
      pc       <= '0;
      sflag    <= 1'b0;
      out_data <= '0;
      out_stb  <= 1'b0;
      sw_take  <= 1'b0;
    end else begin
      out_stb <= 1'b0;
      sw_take <= 1'b0;
      if (state == ST_FETCH) begin
        ir    <= instr_t'(prog_data[7:0]);
        pc    <= pc_inc;
        state <= ST_EXEC;
      end else begin
        state <= ST_FETCH;
        case (ir.op)
          OP_LDI:         pc <= pc_inc;
          OP_JNN:         pc <= sflag ? pc_inc : target;
          OP_JMP:         pc <= target;
          OP_TST, OP_CMP: sflag <= alu_y[DW-1];
          OP_OUT: begin
            out_data <= rs_val;
            out_stb  <= 1'b1;
          end
          OP_INP: begin
            if (sw_valid) sw_take <= 1'b1;
            else          state   <= ST_EXEC;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NREG = 3
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] sw_data,
  input  logic          sw_valid,
  output logic          sw_take,
  output logic [DW-1:0] out_data,
  output logic          out_stb
);

  localparam int SW = 2;

  logic [SW-1:0] sel_rs;
  logic [SW-1:0] sel_rd;
  logic [DW-1:0] rs_val;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] alu_y;
  logic [DW-1:0] rf_wdata;
  logic          rf_we;
  alu_op_e       alu_op;

  cpu8_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .prog_data(prog_data),
    .sw_data  (sw_data),
    .sw_valid (sw_valid),
    .rs_val   (rs_val),
    .alu_y    (alu_y),
    .pc       (prog_addr),
    .sel_rs   (sel_rs),
    .sel_rd   (sel_rd),
    .alu_op   (alu_op),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata),
    .out_data (out_data),
    .out_stb  (out_stb),
    .sw_take  (sw_take)
  );

  cpu8_regfile #(.DW(DW), .NREG(NREG), .SW(SW)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (sel_rd),
    .wdata  (rf_wdata),
    .raddr_a(sel_rs),
    .raddr_b(sel_rd),
    .rdata_a(rs_val),
    .rdata_b(rd_val)
  );

  cpu8_alu #(.DW(DW)) u_alu (
    .op(alu_op),
    .a (rs_val),
    .b (rd_val),
    .y (alu_y)
  );

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] prog_addr,
  input logic [DW-1:0] prog_data,
  input logic          sw_valid,
  input logic          sw_take,
  input logic          out_stb
);

  // R1: reset clears the address and both strobes
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (prog_addr == '0) && !out_stb && !sw_take);

  // R2, R5, R6: the program address steps by one or loads the operand byte
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(prog_addr) |->
      (prog_addr == $past(prog_addr) + AW'(1)) || (prog_addr == AW'($past(prog_data))));

  // R8: acknowledge is a single cycle
  p_take_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    sw_take |=> !sw_take);

  // R8: acknowledge only follows a cycle with valid high
  p_take_valid_r8: assert property (@(posedge clk) disable iff (rst)
    sw_take |-> $past(sw_valid));

  // R9: output strobe is a single cycle
  p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);

  // R9: output strobe and input acknowledge never coincide
  p_strobes_apart_r9: assert property (@(posedge clk) disable iff (rst)
    !(out_stb && sw_take));

endmodule

bind cpu8_core cpu8_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .prog_addr(prog_addr),
  .prog_data(prog_data),
  .sw_valid (sw_valid),
  .sw_take  (sw_take),
  .out_stb  (out_stb)
);

// File: tb/cpu8_core_tb_top.sv
`timescale 1ns/1ps
module cpu8_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] prog_addr;
  logic [7:0] prog_data;
  logic [7:0] sw_data  = 8'h00;
  logic       sw_valid = 1'b0;
  logic       sw_take;
  logic [7:0] out_data;
  logic       out_stb;

  logic [7:0] mem [256];
  logic [7:0] outs [$];
  logic [7:0] in_q [$];
  logic [7:0] expq [$];
  int n_chk = 0;
  int n_bad = 0;
  int wp    = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  assign prog_data = mem[prog_addr];

  cpu8_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .prog_addr(prog_addr),
    .prog_data(prog_data),
    .sw_data  (sw_data),
    .sw_valid (sw_valid),
    .sw_take  (sw_take),
    .out_data (out_data),
    .out_stb  (out_stb)
  );

  // Input feeder and output monitor, both on the falling edge
  always @(negedge clk) begin
    if (!rst && sw_take && in_q.size() > 0) void'(in_q.pop_front());
    sw_valid = (in_q.size() > 0);
    sw_data  = sw_valid ? in_q[0] : 8'h00;
    if (!rst && out_stb) outs.push_back(out_data);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (R13 run hung) act=%0d exp<=%0d cycles", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    n_chk++;
    if (outs.size() != expq.size()) begin
      n_bad++;
      $display("FAIL %s output count act=%0d exp=%0d", tag, outs.size(), expq.size());
    end else begin
      for (int i = 0; i < expq.size(); i++) begin
        if (outs[i] !== expq[i]) begin
          n_bad++;
          $display("FAIL %s output %0d act=%h exp=%h", tag, i, outs[i], expq[i]);
          break;
        end
      end
    end
  endtask

  task automatic emit(input logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  task automatic halt();
    int here = wp;
    emit(8'hB0);
    emit(8'(here));
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    outs.delete();
    in_q.delete();
    expq.delete();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic go(input int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] neg_mag(input logic [7:0] v [5]);
    int best = -128;
    for (int i = 0; i < 5; i++)
      if (v[i][7] && int'($signed(v[i])) > best) best = int'($signed(v[i]));
    return 8'(-best);
  endfunction

  // R2, R9: immediate loads and outputs
  task automatic t_ldi_out(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    begin_prog();
    emit(8'h30); emit(a); emit(8'h31); emit(b); emit(8'h32); emit(c);
    emit(8'hD0); emit(8'hD4); emit(8'hD8);
    halt();
    go(40);
    expq.push_back(a); expq.push_back(b); expq.push_back(c);
    check_outs("R2 R9 load immediate then output");
    chk(prog_addr == 8'd9 || prog_addr == 8'd10, "R2 address counts operand bytes", prog_addr, 9);
  endtask

  // R7, R10: increment, negate, copy
  task automatic t_arith(input logic [7:0] a);
    begin_prog();
    emit(8'h31); emit(a); emit(8'h61); emit(8'hD4);
    emit(8'h32); emit(a); emit(8'hC2); emit(8'hD8);
    emit(8'hA8); emit(8'hD0);
    halt();
    go(50);
    expq.push_back(8'(a + 8'd1)); expq.push_back(8'(8'd0 - a)); expq.push_back(8'(8'd0 - a));
    check_outs("R7 R10 inc/neg/copy");
  endtask

  // R3, R5: test then branch if not negative
  task automatic t_test(input logic [7:0] a);
    begin_prog();
    emit(8'h30); emit(a); emit(8'h31); emit(8'h5A);
    emit(8'h40); emit(8'h50); emit(8'd8);
    emit(8'hD0); emit(8'hD4);
    halt();
    go(40);
    if (a[7]) expq.push_back(a);
    expq.push_back(8'h5A);
    check_outs("R3 R5 test flag and conditional jump");
  endtask

  // R4, R5: compare Rs-Rd then branch
  task automatic t_cmp(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d = a - b;
    begin_prog();
    emit(8'h30); emit(a); emit(8'h31); emit(b);
    emit(8'h91); emit(8'h50); emit(8'd8);
    emit(8'hD0); emit(8'hD4);
    halt();
    go(40);
    if (d[7]) expq.push_back(a);
    expq.push_back(b);
    check_outs("R4 R5 compare flag and conditional jump");
  endtask

  // R11: only test/compare move the flag
  task automatic t_keep(input logic [7:0] v0, input logic [7:0] v1,
                        input logic [7:0] v2, input logic [7:0] vin);
    begin_prog();
    emit(8'h30); emit(v0); emit(8'h40);
    emit(8'h31); emit(v1); emit(8'h61);
    emit(8'h32); emit(v2); emit(8'hC2);
    emit(8'hA4); emit(8'h71);
    emit(8'h50); emit(8'd14);
    emit(8'hD8); emit(8'hD0);
    halt();
    in_q.push_back(vin);
    go(80);
    if (v0[7]) expq.push_back(8'(8'd0 - v2));
    expq.push_back(8'(v1 + 8'd1));
    check_outs("R11 flag kept across inc/neg/copy/input/load");
  endtask

  // R12: register code 11 and undefined operations
  task automatic t_undef();
    begin_prog();
    emit(8'h30); emit(8'h33); emit(8'h31); emit(8'h44);
    emit(8'h32); emit(8'h55); emit(8'h33); emit(8'h99);
    emit(8'hAD);
    emit(8'h00); emit(8'h1F); emit(8'h2F); emit(8'h8F); emit(8'hE5); emit(8'hF0);
    emit(8'hD0); emit(8'hD4); emit(8'hD8); emit(8'hDC);
    halt();
    go(80);
    expq.push_back(8'h33); expq.push_back(8'h00); expq.push_back(8'h55); expq.push_back(8'h00);
    check_outs("R12 code 11 discarded and reads zero, undefined ops silent");
    chk(prog_addr == 8'd19 || prog_addr == 8'd20, "R12 undefined ops are one byte", prog_addr, 19);
  endtask

  // R6: unconditional jump skips code
  task automatic t_jmp();
    begin_prog();
    emit(8'hB0); emit(8'd5); emit(8'hD0); emit(8'hD0); emit(8'hD0);
    emit(8'h30); emit(8'h77); emit(8'hD0);
    halt();
    go(40);
    expq.push_back(8'h77);
    check_outs("R6 unconditional jump");
  endtask

  // R8: input stalls without valid, one byte per instruction
  task automatic t_stall(input logic [7:0] v, input logic [7:0] w);
    begin_prog();
    emit(8'h71); emit(8'hD4);
    halt();
    go(20);
    chk(prog_addr == 8'd1, "R8 address held while waiting", prog_addr, 1);
    chk(outs.size() == 0, "R8 nothing output while waiting", outs.size(), 0);
    @(posedge clk);
    in_q.push_back(v);
    in_q.push_back(w);
    repeat (20) @(negedge clk);
    expq.push_back(v);
    check_outs("R8 input captured after valid");
    chk(in_q.size() == 1, "R8 exactly one byte taken", in_q.size(), 1);
  endtask

  // R13: largest negative magnitude search
  task automatic t_prog(input logic [7:0] v [5]);
    begin_prog();
    emit(8'h30); emit(8'hFB); emit(8'h32); emit(8'h80);
    emit(8'h40); emit(8'h50); emit(8'd18);
    emit(8'h60); emit(8'h71); emit(8'h41); emit(8'h50); emit(8'd4);
    emit(8'h99); emit(8'h50); emit(8'd4);
    emit(8'hA6); emit(8'hB0); emit(8'd4);
    emit(8'hC2); emit(8'hD8);
    halt();
    for (int i = 0; i < 5; i++) in_q.push_back(v[i]);
    go(300);
    expq.push_back(neg_mag(v));
    check_outs("R13 largest negative magnitude");
  endtask

  initial begin
    logic [7:0] rv [5];
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(prog_addr == 8'h00, "R1 address in reset", prog_addr, 0);
    chk(!out_stb && !sw_take, "R1 strobes low in reset", {out_stb, sw_take}, 0);
    void'($urandom(32'd4711));

    t_ldi_out(8'h00, 8'hFF, 8'h80);
    t_arith(8'h80); t_arith(8'hFF); t_arith(8'h7F); t_arith(8'h00);
    t_test(8'h80); t_test(8'h7F); t_test(8'h00);
    t_cmp(8'h7F, 8'hFF); t_cmp(8'h05, 8'h05); t_cmp(8'h80, 8'h01); t_cmp(8'h02, 8'h03);
    t_keep(8'h80, 8'h05, 8'hFB, 8'h03);
    t_keep(8'h01, 8'h7F, 8'h05, 8'h90);
    t_undef();
    t_jmp();
    t_stall(8'hA5, 8'h3C);
    rv = '{8'h82, 8'h01, 8'h02, 8'h03, 8'hFE}; t_prog(rv);
    rv = '{8'h01, 8'h02, 8'h7F, 8'h00, 8'h10}; t_prog(rv);
    rv = '{8'h80, 8'hFF, 8'h80, 8'h00, 8'h01}; t_prog(rv);

    for (int k = 0; k < 8; k++) begin
      t_ldi_out(8'($urandom), 8'($urandom), 8'($urandom));
      t_arith(8'($urandom));
      t_test(8'($urandom));
      t_cmp(8'($urandom), 8'($urandom));
      t_keep(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      for (int i = 0; i < 5; i++) rv[i] = 8'($urandom);
      t_prog(rv);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule